// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Table

This block holds the programmable state of an I/O interrupt routing unit: an identifier register, a read-only version word and a table of 64-bit redirection entries. Software never addresses these registers directly. It first writes an index into a select register, then reads or writes a data window, and the window acts on whichever internal register the current index names. Each 64-bit entry occupies two consecutive indices, low half first.

The block models only storage and indexing. It does not turn input pins into interrupt messages, and it has no system bus protocol. The bus side is one access per cycle: a valid strobe, a write flag, a byte offset and write data. Read data is combinational on the current offset and select value. Writes take effect at the next rising clock edge. After reset every entry is masked, so no source is routed until software programs it.

Top module: `irq_redir_table`

## Requirements
- R1: A write at byte offset 0x00 stores bus_wdata_i[7:0] as the select index. A read at offset 0x00 returns that index zero-extended to 32 bits. The index resets to 0.
- R2: An access at byte offset 0x10 targets the register named by the select index in effect in that same cycle. After the select index changes, the very next window read returns the newly selected register.
- R3: Index 0x01 is the version word. Bits 23:16 hold the highest entry number (NUM_ENT-1, which is 23 by default), bits 7:0 hold the code 0x11, and all other bits are 0. Window writes to index 0x01 have no effect.
- R4: Index 0x00 is the identifier register. Only bits 31:24 are stored and writable; bits 23:0 always read 0. The register resets to 0.
- R5: Entry n has its low half at index 0x10+2n and its high half at index 0x10+2n+1. All 32 bits of each half are writable, and each half reads back the last value written to it.
- R6: After reset, every low half reads 0x00010000 (mask bit 16 set) and every high half reads 0.
- R7: Window accesses at unimplemented indices (0x02 to 0x0F, and 0x10+2*NUM_ENT upward) read 0, and writes to them change no register.
- R8: Accesses at any byte offset other than 0x00 and 0x10 read 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Access strobe for this cycle |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current offset and select index |

## Verification
The assertions assume that reads are sampled only while bus_valid_i is high with bus_we_i low. They also assume that the bus inputs stay constant between clock edges, so a select write that lands at one edge governs the window from the next cycle on. The bench keeps to both assumptions: it changes inputs only at the falling edge and issues exactly one access per cycle. Its random phase draws select values that cover the identifier index, the version index, every table index and unimplemented indices, and it mixes in offsets that decode to nothing.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int DATA_W   = 32;
  localparam int OFF_SEL  = 'h00;
  localparam int OFF_WIN  = 'h10;
  localparam int IDX_ID   = 'h00;
  localparam int IDX_VER  = 'h01;
  localparam int TBL_BASE = 'h10;
  localparam int MASK_BIT = 16;
  localparam logic [7:0] VER_CODE = 8'h11;
  localparam logic [DATA_W-1:0] RST_LO = DATA_W'(1) << MASK_BIT;
endpackage

// File: rtl/irq_sel_reg.sv
module irq_sel_reg #(
  parameter int SEL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wdata_i,
  output logic [SEL_W-1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_o <= '0;
    else if (wr_en_i) sel_o <= wdata_i;
  end
endmodule

// File: rtl/irq_id_reg.sv
module irq_id_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] id_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      id_o <= '0;
    else if (wr_en_i) id_o <= wdata_i;
  end
endmodule

// File: rtl/irq_entry_bank.sv
module irq_entry_bank
  import irq_redir_pkg::*;
#(
  parameter int NUM_ENT = 24,
  parameter int SEL_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int EW   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int LAST = TBL_BASE + 2 * NUM_ENT;

  logic [SEL_W-1:0] rel;
  logic [EW-1:0]    ent;
  logic             half;
  logic [NUM_ENT-1:0][DATA_W-1:0] lo_all, hi_all;

  assign rel   = idx_i - SEL_W'(TBL_BASE);
  assign hit_o = (int'(idx_i) >= TBL_BASE) && (int'(idx_i) < LAST);
  assign half  = rel[0];
  assign ent   = rel[EW:1];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic [DATA_W-1:0] lo_q, hi_q;
    logic              sel_me;
    assign sel_me = wr_en_i && hit_o && (ent == EW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= RST_LO;   // masked after reset
        hi_q <= '0;
      end else if (sel_me) begin
        if (half) hi_q <= wdata_i;
        else      lo_q <= wdata_i;
      end
    end
    assign lo_all[g] = lo_q;
    assign hi_all[g] = hi_q;
  end

  always_comb begin
    rdata_o = '0;
    if (hit_o) rdata_o = half ? hi_all[ent] : lo_all[ent];
  end
endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_redir_pkg::*;
#(
  parameter int NUM_ENT = 24,
  parameter int SEL_W   = 8,
  parameter int ADDR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o
);
  localparam logic [DATA_W-1:0] VER_WORD =
    {8'h00, 8'(NUM_ENT - 1), 8'h00, VER_CODE};

  logic             at_sel, at_win, sel_wr, win_wr, tbl_hit;
  logic [SEL_W-1:0] sel_q;
  logic [7:0]       id_q;
  logic [DATA_W-1:0] tbl_rdata, win_rdata;

  assign at_sel = (bus_addr_i == ADDR_W'(OFF_SEL));
  assign at_win = (bus_addr_i == ADDR_W'(OFF_WIN));
  assign sel_wr = bus_valid_i && bus_we_i && at_sel;
  assign win_wr = bus_valid_i && bus_we_i && at_win;

  irq_sel_reg #(.SEL_W(SEL_W)) u_sel (
    .clk_i, .rst_ni,
    .wr_en_i (sel_wr),
    .wdata_i (bus_wdata_i[SEL_W-1:0]),
    .sel_o   (sel_q)
  );

  irq_id_reg u_id (
    .clk_i, .rst_ni,
    .wr_en_i (win_wr && (sel_q == SEL_W'(IDX_ID))),
    .wdata_i (bus_wdata_i[31:24]),
    .id_o    (id_q)
  );

  irq_entry_bank #(.NUM_ENT(NUM_ENT), .SEL_W(SEL_W)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i (win_wr),
    .idx_i   (sel_q),
    .wdata_i (bus_wdata_i),
    .hit_o   (tbl_hit),
    .rdata_o (tbl_rdata)
  );

  always_comb begin
    if (sel_q == SEL_W'(IDX_ID))       win_rdata = {id_q, 24'h0};
    else if (sel_q == SEL_W'(IDX_VER)) win_rdata = VER_WORD;
    else if (tbl_hit)                  win_rdata = tbl_rdata;
    else                               win_rdata = '0;
  end

  always_comb begin
    if (at_sel)      bus_rdata_o = DATA_W'(sel_q);
    else if (at_win) bus_rdata_o = win_rdata;
    else             bus_rdata_o = '0;
  end
endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk
  import irq_redir_pkg::*;
#(
  parameter int NUM_ENT = 24,
  parameter int SEL_W   = 8,
  parameter int ADDR_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [SEL_W-1:0]  sel_q
);
  localparam int LAST = TBL_BASE + 2 * NUM_ENT;
  logic rd, win_rd, sel_wr, unimpl;
  assign rd     = bus_valid_i && !bus_we_i;
  assign win_rd = rd && (bus_addr_i == ADDR_W'(OFF_WIN));
  assign sel_wr = bus_valid_i && bus_we_i && (bus_addr_i == ADDR_W'(OFF_SEL));
  assign unimpl = (int'(sel_q) > IDX_VER && int'(sel_q) < TBL_BASE) || (int'(sel_q) >= LAST);

  p_sel_store_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr |=> sel_q == $past(bus_wdata_i[SEL_W-1:0]));
  p_sel_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_wr |=> $stable(sel_q));
  p_sel_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bus_addr_i == ADDR_W'(OFF_SEL)) |-> bus_rdata_o == DATA_W'(sel_q));
  p_ver_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_rd && sel_q == SEL_W'(IDX_VER)) |->
      bus_rdata_o == {8'h00, 8'(NUM_ENT - 1), 8'h00, VER_CODE});
  p_id_low_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_rd && sel_q == SEL_W'(IDX_ID)) |-> bus_rdata_o[23:0] == 24'h0);
  p_unimpl_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_rd && unimpl) |-> bus_rdata_o == '0);
  p_bad_offset_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bus_addr_i != ADDR_W'(OFF_SEL) && bus_addr_i != ADDR_W'(OFF_WIN))
      |-> bus_rdata_o == '0);
endmodule

bind irq_redir_table irq_redir_chk #(
  .NUM_ENT(NUM_ENT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_valid_i(bus_valid_i),
  .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o), .sel_q(sel_q)
);

// File: tb/tb_irq_redir_table.sv
module tb_irq_redir_table;
  localparam int N = 24;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        valid = 0, we = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  string force_tag = "";

  // reference model
  int unsigned m_lo[N], m_hi[N];
  int unsigned m_sel, m_id;
  int unsigned rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  irq_redir_table dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  function automatic int unsigned nxt();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  function automatic int unsigned win_val(int unsigned s);
    if (s == 0) return m_id << 24;
    if (s == 1) return 32'h0017_0011;
    if (s >= 16 && s < 16 + 2*N) return ((s - 16) % 2) ? m_hi[(s-16)/2] : m_lo[(s-16)/2];
    return 0;
  endfunction

  function automatic int unsigned exp_rd(logic [4:0] a);
    if (a == 5'h00) return m_sel;
    if (a == 5'h10) return win_val(m_sel);
    return 0;
  endfunction

  function automatic string tag_of(logic [4:0] a);
    if (force_tag != "") return force_tag;
    if (a == 5'h00) return "R1";
    if (a != 5'h10) return "R8";
    if (m_sel == 0) return "R4";
    if (m_sel == 1) return "R3";
    if (m_sel >= 16 && m_sel < 16 + 2*N) return "R5";
    return "R7";
  endfunction

  task automatic check_now(string t);
    int unsigned e;
    e = exp_rd(addr);
    checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s addr=%h sel=%h actual=%h expected=%h", t, addr, m_sel, rdata, e);
    end
  endtask

  task automatic op(bit w, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    valid = 1; we = w; addr = a; wdata = d;
    #1 check_now(tag_of(a));
    @(posedge clk);
    if (w) begin
      if (a == 5'h00) m_sel = d[7:0];
      else if (a == 5'h10) begin
        if (m_sel == 0) m_id = d[31:24];
        else if (m_sel >= 16 && m_sel < 16 + 2*N) begin
          if ((m_sel - 16) % 2) m_hi[(m_sel-16)/2] = d;
          else m_lo[(m_sel-16)/2] = d;
        end
      end
    end
  endtask

  task automatic wsel(int unsigned s); op(1, 5'h00, 32'(s)); endtask
  task automatic rwin(); op(0, 5'h10, 0); endtask
  task automatic wwin(logic [31:0] d); op(1, 5'h10, d); endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_lo[i] = 32'h0001_0000; m_hi[i] = 0; end
    m_sel = 0; m_id = 0;
    repeat (3) @(posedge clk);
    // reset state while reset is held (R1)
    @(negedge clk); addr = 5'h00; #1 check_now("R1");
    @(negedge clk); rst_n = 1;

    // R6: every entry masked after reset
    force_tag = "R6";
    for (int i = 0; i < 2*N; i++) begin wsel(16 + i); rwin(); end
    force_tag = "";

    // R4 identifier
    wsel(0); rwin();
    wwin(32'hFFFF_FFFF); rwin();
    wwin(32'hA5_123456); rwin();
    // R3 version, write ignored
    wsel(1); rwin(); wwin(32'hFFFF_FFFF); rwin();
    // R5 entries: distinct patterns in first and last entry, both halves
    wsel(16); wwin(32'hDEAD_BEEF); rwin();
    wsel(17); wwin(32'h0F00_0001); rwin();
    wsel(16 + 2*N - 2); wwin(32'h1234_5678); rwin();
    wsel(16 + 2*N - 1); wwin(32'h8765_4321); rwin();
    wsel(18); rwin();   // neighbour untouched
    // R2: change select between reads
    force_tag = "R2";
    wsel(16); rwin(); wsel(17); rwin(); wsel(0); rwin();
    force_tag = "";
    // R7 unimplemented indices, writes ignored
    wsel(2);  wwin(32'hFFFF_FFFF); rwin();
    wsel(15); wwin(32'hFFFF_FFFF); rwin();
    wsel(16 + 2*N); wwin(32'hFFFF_FFFF); rwin();
    wsel(255); wwin(32'hFFFF_FFFF); rwin();
    force_tag = "R7";
    wsel(16); rwin(); wsel(0); rwin();
    force_tag = "";
    // R8 other offsets
    wsel(16);
    op(1, 5'h04, 32'hFFFF_FFFF); op(0, 5'h04, 0);
    op(1, 5'h14, 32'hFFFF_FFFF); op(0, 5'h1F, 0);
    force_tag = "R8"; rwin(); op(0, 5'h00, 0); force_tag = "";
    // R1 select readback of arbitrary values
    op(1, 5'h00, 32'hFFFF_FF9C); op(0, 5'h00, 0);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      int unsigned r, s, sp;
      logic [4:0] a;
      r = nxt(); s = nxt();
      case (s % 6)
        0: sp = 0;
        1: sp = 1;
        2: sp = s[15:8];
        default: sp = 16 + (s[15:8] % (2*N));
      endcase
      case (r % 8)
        3:       a = 5'h00;
        4:       a = 5'(r >> 8);
        default: a = 5'h10;
      endcase
      if (a == 5'h00 && r[12]) op(1, a, {s[31:8], 8'(sp)});
      else op(r[13], a, nxt());
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule